// File: doc/BRIEF.md
# Load Fence Ordering Gate

This block stands between an in-order stream of memory operations and a memory port that may finish loads in any order. Each cycle it takes at most one tagged operation through a valid/ready handshake and, when the operation may go, passes it on to the port in the same cycle. It keeps two counts: loads issued but not yet visible to the whole system, and stores issued but not yet complete. A completion pulse per load (and per store) lowers the matching count.

A load barrier is the central case. Once accepted, it holds back every later load, and every later barrier or serializing operation, until all loads older than it have been reported visible. Stores, store barriers and prefetch hints keep flowing past it. A full barrier and a serializing operation are stricter: they wait for both counts to drain and block operations of every kind while they wait. Barriers are absorbed by the gate but still appear on the issue side in the cycle they are accepted, so the port sees the complete program order. A small decoder beside the gate recognises the load-barrier encoding from two opcode bytes and the reg field of the ModRM byte. Fence operations never raise a fault, so the block has no fault output.

Top module: `load_fence_gate`

## Requirements
- R1: After a load barrier (kind code 2) is accepted while the outstanding-load count is non-zero, a load (kind 0) presented later is not ready. The barrier retires in the cycle the registered load count reads zero. Loads become ready in the cycle after that.
- R2: While a load barrier is pending, another load barrier, a full barrier (kind 4) or a serializing operation (kind 5) is not ready.
- R3: While a load barrier is pending, a store (kind 1) and a store barrier (kind 3) are ready and issue in the same cycle.
- R4: While a load barrier is pending, a prefetch hint (kind 6) is ready and issues in the same cycle.
- R5: A load barrier accepted while the load count is zero leaves nothing pending. A load presented in the next cycle is ready.
- R6: A full barrier or serializing operation accepted while either count is non-zero blocks every kind of operation. It retires in the cycle both registered counts read zero, and operations are ready again in the cycle after that.
- R7: The decoder flag is 1 exactly when the first opcode byte is 0x0F, the second is 0xAE, and ModRM bits [5:3] equal 5. The mod and r/m bits are ignored.
- R8: With CNT_W-bit counters, a load is not ready while 2^CNT_W-1 loads are outstanding. It becomes ready again in the cycle after a completion lowers the count.
- R9: After reset nothing is pending and both counts are zero. in_ready is low whenever the presented operation is stalled. issue_valid, issue_kind and issue_tag repeat the accepted operation in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The presented operation may go this cycle |
| in_kind | input | 3 | Operation kind: 0 load, 1 store, 2 load barrier, 3 store barrier, 4 full barrier, 5 serializing, 6 prefetch, 7 unordered no-op |
| in_tag | input | TAG_W | Tag of the presented operation |
| issue_valid | output | 1 | An operation is issued to the memory port |
| issue_kind | output | 3 | Kind of the issued operation |
| issue_tag | output | TAG_W | Tag of the issued operation |
| ld_done | input | 1 | One outstanding load became globally visible |
| st_done | input | 1 | One outstanding store completed |
| dec_op0 | input | 8 | First opcode byte to decode |
| dec_op1 | input | 8 | Second opcode byte to decode |
| dec_modrm | input | 8 | ModRM byte to decode |
| dec_is_ld_barrier | output | 1 | Decoded bytes form the load-barrier encoding |

## Verification
On every cycle, the assertions check that no load issues while a load barrier is pending. They also check that a pending load barrier stays until the load count reads zero and then leaves, that nothing at all issues under a pending full barrier, that a store with room is never held by a load barrier alone, and that neither counter wraps. Only the bench's scenarios can show the exact cycle in which ready returns after the last completion pulse. The same holds for the immediate retire of a barrier that finds no loads in flight, the saturation stall at the counter limit, and the decoder's response to near-miss encodings.

// File: rtl/lfg_pkg.sv
package lfg_pkg;

    typedef enum logic [2:0] {
        OP_LOAD         = 3'd0,
        OP_STORE        = 3'd1,
        OP_LD_BARRIER   = 3'd2,
        OP_ST_BARRIER   = 3'd3,
        OP_FULL_BARRIER = 3'd4,
        OP_SERIAL       = 3'd5,
        OP_PREFETCH     = 3'd6,
        OP_NOP          = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic ld_pend;
        logic full_pend;
    } gate_state_t;

    localparam logic [7:0] ESC_BYTE      = 8'h0F;
    localparam logic [7:0] GROUP_BYTE    = 8'hAE;
    localparam logic [2:0] LDB_REG_FIELD = 3'd5;

endpackage

// File: rtl/lfg_opcode_decode.sv
module lfg_opcode_decode
    import lfg_pkg::*;
(
    input  logic [7:0] op0,
    input  logic [7:0] op1,
    input  logic [7:0] modrm,
    output logic       is_ld_barrier
);

    logic [2:0] reg_field;

    always_comb begin
        reg_field     = modrm[5:3];
        is_ld_barrier = (op0 == ESC_BYTE) && (op1 == GROUP_BYTE) &&
                        (reg_field == LDB_REG_FIELD);
    end

endmodule

// File: rtl/lfg_outstanding_ctr.sv
module lfg_outstanding_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_full
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !(dec && cnt_q != '0)) begin
            cnt_d = cnt_q + 1'b1;
        end else if (!inc && dec && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        is_zero = (cnt_q == '0);
        is_full = (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX)); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q != '0)); // R8

endmodule

// File: rtl/lfg_order_policy.sv
module lfg_order_policy
    import lfg_pkg::*;
(
    input  op_kind_e kind,
    input  logic     ld_pend,
    input  logic     full_pend,
    input  logic     ld_full,
    input  logic     st_full,
    output logic     head_ok
);

    always_comb begin
        head_ok = 1'b0;
        if (!full_pend) begin
            unique case (kind)
                OP_LOAD:         head_ok = !ld_pend && !ld_full;
                OP_STORE:        head_ok = !st_full;
                OP_LD_BARRIER,
                OP_FULL_BARRIER,
                OP_SERIAL:       head_ok = !ld_pend;
                OP_ST_BARRIER,
                OP_PREFETCH,
                OP_NOP:          head_ok = 1'b1;
                default:         head_ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/load_fence_gate.sv
module load_fence_gate
    import lfg_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_kind,
    input  logic [TAG_W-1:0] in_tag,
    output logic             issue_valid,
    output logic [2:0]       issue_kind,
    output logic [TAG_W-1:0] issue_tag,
    input  logic             ld_done,
    input  logic             st_done,
    input  logic [7:0]       dec_op0,
    input  logic [7:0]       dec_op1,
    input  logic [7:0]       dec_modrm,
    output logic             dec_is_ld_barrier
);

    gate_state_t st_d, st_q;
    op_kind_e    kind;
    logic        head_ok, accept;
    logic        ld_zero, ld_full, st_zero, st_full;
    logic        ld_inc, st_inc;

    lfg_opcode_decode u_dec (
        .op0           (dec_op0),
        .op1           (dec_op1),
        .modrm         (dec_modrm),
        .is_ld_barrier (dec_is_ld_barrier)
    );

    lfg_order_policy u_policy (
        .kind      (kind),
        .ld_pend   (st_q.ld_pend),
        .full_pend (st_q.full_pend),
        .ld_full   (ld_full),
        .st_full   (st_full),
        .head_ok   (head_ok)
    );

    lfg_outstanding_ctr #(.CNT_W(CNT_W)) u_ld_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (ld_inc),
        .dec     (ld_done),
        .is_zero (ld_zero),
        .is_full (ld_full)
    );

    lfg_outstanding_ctr #(.CNT_W(CNT_W)) u_st_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (st_inc),
        .dec     (st_done),
        .is_zero (st_zero),
        .is_full (st_full)
    );

    always_comb begin
        kind   = op_kind_e'(in_kind);
        accept = in_valid && head_ok;
        ld_inc = accept && (kind == OP_LOAD);
        st_inc = accept && (kind == OP_STORE);
        st_d   = st_q;

        if (st_q.ld_pend && ld_zero)
            st_d.ld_pend = 1'b0;
        if (st_q.full_pend && ld_zero && st_zero)
            st_d.full_pend = 1'b0;

        if (accept) begin
            case (kind)
                OP_LD_BARRIER:
                    if (!ld_zero) st_d.ld_pend = 1'b1;
                OP_FULL_BARRIER, OP_SERIAL:
                    if (!(ld_zero && st_zero)) st_d.full_pend = 1'b1;
                default: ;
            endcase
        end

        in_ready    = head_ok;
        issue_valid = accept;
        issue_kind  = in_kind;
        issue_tag   = in_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_LOAD_UNDER_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_kind == OP_LOAD) |-> !st_q.ld_pend); // R1

    AST_BARRIER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ld_pend && !ld_zero) |=> st_q.ld_pend); // R1

    AST_BARRIER_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ld_pend && ld_zero) |=> !st_q.ld_pend); // R1

    AST_STORE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == OP_STORE && st_q.ld_pend && !st_q.full_pend && !st_full)
            |-> issue_valid); // R3

    AST_FULL_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full_pend |-> !issue_valid); // R6

endmodule

// File: tb/load_fence_gate_test.sv
module load_fence_gate_test;
    import lfg_pkg::*;

    localparam int TAG_W = 6;
    localparam int CNT_W = 4;
    localparam int LIMIT = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [2:0]       in_kind;
    logic [TAG_W-1:0] in_tag;
    logic             issue_valid;
    logic [2:0]       issue_kind;
    logic [TAG_W-1:0] issue_tag;
    logic             ld_done, st_done;
    logic [7:0]       dec_op0, dec_op1, dec_modrm;
    logic             dec_is_ld_barrier;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    load_fence_gate #(.TAG_W(TAG_W), .CNT_W(CNT_W)) uut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_kind (in_kind), .in_tag (in_tag),
        .issue_valid (issue_valid), .issue_kind (issue_kind), .issue_tag (issue_tag),
        .ld_done (ld_done), .st_done (st_done),
        .dec_op0 (dec_op0), .dec_op1 (dec_op1), .dec_modrm (dec_modrm),
        .dec_is_ld_barrier (dec_is_ld_barrier)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present an operation at the falling edge and let combinational outputs settle.
    task automatic present(input op_kind_e k, input int tag, input logic ldd, input logic std);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind  = k;
        in_tag   = TAG_W'(tag);
        ld_done  = ldd;
        st_done  = std;
        #1;
    endtask

    task automatic quiet(input logic ldd, input logic std);
        @(negedge clk);
        in_valid = 1'b0;
        ld_done  = ldd;
        st_done  = std;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b0; in_kind = '0; in_tag = '0;
        ld_done = 1'b0; st_done = 1'b0;
        dec_op0 = '0; dec_op1 = '0; dec_modrm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        present(OP_LOAD, 1, 1'b0, 1'b0);
        chk("R9 reset load ready", int'(in_ready), 1);
        chk("R9 issue_valid", int'(issue_valid), 1);
        chk("R9 issue_tag", int'(issue_tag), 1);
        chk("R9 issue_kind", int'(issue_kind), int'(OP_LOAD));
    endtask

    task automatic t_ld_barrier_order;
        present(OP_LD_BARRIER, 2, 1'b0, 1'b0);
        chk("R1 barrier accepted", int'(in_ready), 1);
        present(OP_LOAD, 3, 1'b0, 1'b0);
        chk("R1 load stalled", int'(in_ready), 0);
        chk("R9 no issue when stalled", int'(issue_valid), 0);
        present(OP_STORE, 4, 1'b0, 1'b0);
        chk("R3 store passes", int'(issue_valid), 1);
        present(OP_ST_BARRIER, 5, 1'b0, 1'b0);
        chk("R3 store barrier passes", int'(issue_valid), 1);
        present(OP_PREFETCH, 6, 1'b0, 1'b0);
        chk("R4 prefetch passes", int'(issue_valid), 1);
        present(OP_LD_BARRIER, 7, 1'b0, 1'b0);
        chk("R2 second load barrier waits", int'(in_ready), 0);
        present(OP_FULL_BARRIER, 8, 1'b0, 1'b0);
        chk("R2 full barrier waits", int'(in_ready), 0);
        present(OP_SERIAL, 9, 1'b0, 1'b0);
        chk("R2 serializing waits", int'(in_ready), 0);
        present(OP_LOAD, 10, 1'b1, 1'b0);
        chk("R1 load stalled in completion cycle", int'(in_ready), 0);
        present(OP_LOAD, 10, 1'b0, 1'b0);
        chk("R1 load stalled in retire cycle", int'(in_ready), 0);
        present(OP_LOAD, 10, 1'b0, 1'b0);
        chk("R1 load released after retire", int'(in_ready), 1);
        quiet(1'b1, 1'b1);
        quiet(1'b0, 1'b0);
    endtask

    task automatic t_zero_count_barrier;
        present(OP_LD_BARRIER, 11, 1'b0, 1'b0);
        chk("R5 barrier accepted at zero", int'(in_ready), 1);
        present(OP_LOAD, 12, 1'b0, 1'b0);
        chk("R5 load not stalled", int'(in_ready), 1);
        quiet(1'b1, 1'b0);
        quiet(1'b0, 1'b0);
    endtask

    task automatic t_full_barrier;
        present(OP_LOAD, 13, 1'b0, 1'b0);
        present(OP_FULL_BARRIER, 14, 1'b0, 1'b0);
        chk("R6 full barrier accepted", int'(in_ready), 1);
        present(OP_PREFETCH, 15, 1'b0, 1'b0);
        chk("R6 prefetch blocked", int'(in_ready), 0);
        present(OP_STORE, 16, 1'b0, 1'b0);
        chk("R6 store blocked", int'(in_ready), 0);
        present(OP_PREFETCH, 15, 1'b1, 1'b0);
        chk("R6 blocked in completion cycle", int'(in_ready), 0);
        present(OP_PREFETCH, 15, 1'b0, 1'b0);
        chk("R6 blocked in retire cycle", int'(in_ready), 0);
        present(OP_PREFETCH, 15, 1'b0, 1'b0);
        chk("R6 released after load drain", int'(issue_valid), 1);
        present(OP_STORE, 17, 1'b0, 1'b0);
        present(OP_SERIAL, 18, 1'b0, 1'b0);
        chk("R6 serializing accepted", int'(in_ready), 1);
        present(OP_LOAD, 19, 1'b0, 1'b0);
        chk("R6 load blocked by store drain", int'(in_ready), 0);
        present(OP_LOAD, 19, 1'b0, 1'b1);
        present(OP_LOAD, 19, 1'b0, 1'b0);
        chk("R6 blocked in retire cycle (store)", int'(in_ready), 0);
        present(OP_LOAD, 19, 1'b0, 1'b0);
        chk("R6 released after store drain", int'(in_ready), 1);
        quiet(1'b1, 1'b0);
        quiet(1'b0, 1'b0);
    endtask

    task automatic t_saturation;
        int ok = 1;
        for (int i = 0; i < LIMIT; i++) begin
            present(OP_LOAD, i, 1'b0, 1'b0);
            if (in_ready !== 1'b1) ok = 0;
        end
        chk("R8 loads below limit accepted", ok, 1);
        present(OP_LOAD, 40, 1'b0, 1'b0);
        chk("R8 load stalled at limit", int'(in_ready), 0);
        present(OP_LOAD, 40, 1'b1, 1'b0);
        chk("R8 stalled in completion cycle", int'(in_ready), 0);
        present(OP_LOAD, 40, 1'b0, 1'b0);
        chk("R8 load accepted after completion", int'(in_ready), 1);
        for (int i = 0; i < LIMIT; i++) quiet(1'b1, 1'b0);
        quiet(1'b0, 1'b0);
        present(OP_LD_BARRIER, 41, 1'b0, 1'b0);
        present(OP_LOAD, 42, 1'b0, 1'b0);
        chk("R8 count drained to zero", int'(in_ready), 1);
        quiet(1'b1, 1'b0);
        quiet(1'b0, 1'b0);
    endtask

    task automatic dec_case(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m, input int exp);
        dec_op0 = a; dec_op1 = b; dec_modrm = m;
        #1;
        chk("R7 decode", int'(dec_is_ld_barrier), exp);
    endtask

    task automatic t_decode;
        dec_case(8'h0F, 8'hAE, 8'hE8, 1);
        dec_case(8'h0F, 8'hAE, 8'h2F, 1);
        dec_case(8'h0F, 8'hAE, 8'hF0, 0);
        dec_case(8'h0F, 8'hAE, 8'hE0, 0);
        dec_case(8'h0F, 8'hAF, 8'hE8, 0);
        dec_case(8'h0E, 8'hAE, 8'hE8, 0);
    endtask

    initial begin
        t_reset();
        t_ld_barrier_order();
        t_zero_count_barrier();
        t_full_barrier();
        t_saturation();
        t_decode();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule